// File: doc/BRIEF.md
# Hybrid Cellular Automaton Pattern Generator

This block produces a stream of pseudo-random test patterns from a one-dimensional row of N cells. Each cell holds one bit. On every enabled clock a cell takes a new value from the XOR of its two neighbours. Cells marked in a per-cell rule mask also include their own current value in that XOR. The mask mixes the two rule kinds so that the row has maximal length: from any nonzero start it steps through all 2^N − 1 nonzero states before it repeats. The full parallel state is the pattern presented to the logic under test.

The next state of a cell depends only on its near neighbours, not on a shift path with one global feedback. Consecutive patterns are therefore less correlated than those of a shift-register generator, which suits tests that apply pairs of patterns. A parallel load sets a new starting state, and a run enable advances the row. The all-zero state is a dead end for this kind of generator, so a zero seed is never accepted: the generator substitutes a fixed nonzero start value.

Top module: `ca_pattern_gen`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the pattern equals the parameter SEED_DEFAULT (default 4'b0001).
- R2: When load_i is high at a clock edge and seed_i is nonzero, the pattern after that edge equals seed_i, whatever the value of run_i.
- R3: When load_i is high at a clock edge and seed_i is zero, the pattern after that edge equals SEED_DEFAULT.
- R4: When run_i is high and load_i is low, bit i of the new pattern is the XOR of old bits i−1 and i+1. Old bit i is also included when RULE_MASK bit i is 1; a 0 in the mask leaves it out. A neighbour index outside 0..N−1 reads as 0.
- R5: When both load_i and run_i are low, the pattern keeps its value.
- R6: With the defaults (N=4, RULE_MASK=4'b1010), free running from 4'b0001 returns to 4'b0001 after exactly 15 steps and visits no state twice in between.
- R7: The pattern is never all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Load seed_i into the cells; takes priority over run_i |
| seed_i | input | N | Start value; zero is replaced by SEED_DEFAULT |
| run_i | input | 1 | Advance the automaton by one step |
| pattern_o | output | N | Current cell states, the test pattern |

## Verification
Loading and stepping can both be requested in the same cycle. The bench raises load_i and run_i together, with nonzero seeds and with the zero seed. It expects the next pattern to be the loaded value, or the default seed for a zero seed, and never the stepped value. Random stretches mix both controls freely. A behavioural model compares the pattern on every clock.

// File: rtl/ca_pkg.sv
package ca_pkg;

    typedef enum logic [1:0] {
        CA_HOLD = 2'd0,
        CA_LOAD = 2'd1,
        CA_STEP = 2'd2
    } ca_op_e;

endpackage

// File: rtl/ca_cell.sv
module ca_cell #(
    parameter bit SELF_TAP = 1'b0
) (
    input  logic nb_lo,
    input  logic own,
    input  logic nb_hi,
    output logic nxt
);

    generate
        if (SELF_TAP) begin : g_rule150
            assign nxt = nb_lo ^ own ^ nb_hi;
        end else begin : g_rule90
            assign nxt = nb_lo ^ nb_hi;
        end
    endgenerate

endmodule

// File: rtl/ca_seed_guard.sv
module ca_seed_guard #(
    parameter int                N            = 4,
    parameter logic [N-1:0]      SEED_DEFAULT = 1
) (
    input  logic [N-1:0] seed_raw,
    output logic [N-1:0] seed_safe
);

    always_comb begin
        seed_safe = (seed_raw == '0) ? SEED_DEFAULT : seed_raw;
    end

endmodule

// File: rtl/ca_pattern_gen.sv
module ca_pattern_gen #(
    parameter int           N            = 4,
    parameter logic [N-1:0] RULE_MASK    = 4'b1010,
    parameter logic [N-1:0] SEED_DEFAULT = 4'b0001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [N-1:0] seed_i,
    input  logic         run_i,
    output logic [N-1:0] pattern_o
);
    import ca_pkg::*;

    localparam int PADW = N + 2;

    typedef struct packed {
        logic [N-1:0] cells;
    } ca_state_t;

    ca_state_t    st_d, st_q;
    ca_op_e       op;
    logic [PADW-1:0] padded;
    logic [N-1:0] stepped;
    logic [N-1:0] seed_ok;

    assign padded = {1'b0, st_q.cells, 1'b0};

    generate
        for (genvar i = 0; i < N; i++) begin : g_cell
            ca_cell #(.SELF_TAP(RULE_MASK[i])) u_cell (
                .nb_lo (padded[i]),
                .own   (padded[i+1]),
                .nb_hi (padded[i+2]),
                .nxt   (stepped[i])
            );
        end
    endgenerate

    ca_seed_guard #(.N(N), .SEED_DEFAULT(SEED_DEFAULT)) u_guard (
        .seed_raw  (seed_i),
        .seed_safe (seed_ok)
    );

    always_comb begin
        if (load_i)     op = CA_LOAD;
        else if (run_i) op = CA_STEP;
        else            op = CA_HOLD;

        st_d = st_q;
        unique case (op)
            CA_LOAD: st_d.cells = seed_ok;
            CA_STEP: st_d.cells = stepped;
            default: st_d.cells = st_q.cells;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cells: SEED_DEFAULT};
        else        st_q <= st_d;
    end

    assign pattern_o = st_q.cells;

    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pattern_o != '0); // R7

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && seed_i != '0) |=> (pattern_o == $past(seed_i))); // R2

    AST_ZERO_SEED_SUBST: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && seed_i == '0) |=> (pattern_o == SEED_DEFAULT)); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !run_i) |=> $stable(pattern_o)); // R5

    AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i) |=> (pattern_o != $past(pattern_o))); // R4

endmodule

// File: tb/ca_pattern_gen_bench.sv
module ca_pattern_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam logic [N-1:0] MASK = 4'b1010;
    localparam logic [N-1:0] DEF  = 4'b0001;

    logic clk = 0;
    logic rst_n = 0;
    logic load_i = 0;
    logic run_i = 0;
    logic [N-1:0] seed_i = '0;
    logic [N-1:0] pattern_o;

    int checks = 0;
    int failures = 0;
    logic [N-1:0] model;

    always #(CLK_PERIOD/2) clk = ~clk;

    ca_pattern_gen u_ca_pattern_gen (
        .clk(clk), .rst_n(rst_n), .load_i(load_i),
        .seed_i(seed_i), .run_i(run_i), .pattern_o(pattern_o)
    );

    function automatic logic [N-1:0] ref_step(input logic [N-1:0] s);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            int lo, hi, me;
            lo = (i > 0)     ? int'(s[i-1]) : 0;
            hi = (i < N - 1) ? int'(s[i+1]) : 0;
            me = MASK[i] ? int'(s[i]) : 0;
            r[i] = ((lo + hi + me) % 2) == 1;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%b exp=%b t=%0t", req, got, exp, $time);
        end
    endtask

    task automatic step(input logic ld, input logic [N-1:0] sd, input logic rn, input string req);
        load_i = ld; seed_i = sd; run_i = rn;
        if (ld)      model = (sd == '0) ? DEF : sd;
        else if (rn) model = ref_step(model);
        @(posedge clk);
        @(negedge clk);
        check(req, pattern_o, model);
        checks++;
        if (pattern_o == '0) begin
            failures++;
            $display("FAIL R7 got=%b exp=nonzero", pattern_o);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog got=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        bit seen [16];
        int period;
        @(negedge clk);
        @(negedge clk);
        check("R1 in reset", pattern_o, DEF);
        rst_n = 1;
        model = DEF;
        @(negedge clk);
        check("R1 after reset", pattern_o, DEF);

        // R6: full period from the default seed
        for (int k = 0; k < 16; k++) seen[k] = 0;
        seen[DEF] = 1;
        period = 0;
        for (int k = 0; k < 20; k++) begin
            step(1'b0, '0, 1'b1, "R4 free run");
            period++;
            if (pattern_o == DEF) break;
            checks++;
            if (seen[pattern_o]) begin
                failures++;
                $display("FAIL R6 got=repeat %b exp=unique", pattern_o);
            end
            seen[pattern_o] = 1;
        end
        checks++;
        if (period != 15) begin
            failures++;
            $display("FAIL R6 got=%0d exp=15", period);
        end

        // R5 hold
        step(1'b0, 4'hF, 1'b0, "R5 idle");
        step(1'b0, 4'h0, 1'b0, "R5 idle");
        // R2 loads, with and without run in the same cycle
        step(1'b1, 4'b1011, 1'b0, "R2 load");
        step(1'b1, 4'b0110, 1'b1, "R2 load+run");
        step(1'b0, '0, 1'b1, "R4 step after load");
        // R3 zero seed
        step(1'b1, 4'b0000, 1'b0, "R3 zero seed");
        step(1'b1, 4'b1111, 1'b0, "R2 load");
        step(1'b1, 4'b0000, 1'b1, "R3 zero seed+run");
        step(1'b1, 4'b1000, 1'b0, "R2 load msb");
        step(1'b0, '0, 1'b1, "R4 edge cell");
        // random mix
        for (int k = 0; k < 300; k++) begin
            logic [N-1:0] sd;
            logic ld, rn;
            sd = N'($urandom);
            ld = ($urandom % 4) == 0;
            rn = ($urandom % 3) != 0;
            step(ld, sd, rn, "R2/R3/R4/R5 mix");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule